// File: doc/BRIEF.md
# DDR Octal Pseudo-Static RAM Bus Master

This block turns single read or write requests from a local interface into transactions on an 8-bit double-data-rate pseudo-static RAM bus. The bus has an active-low select, a bus clock, a bus reset and one bidirectional strobe. The block runs on a system clock. Each system clock cycle carries one bus byte, so the bus clock toggles once per system cycle while a transaction is open. The bus clock therefore runs at half the system rate, and two bytes move per bus clock.

A transaction opens with a 48-bit command/address word, sent as six bytes, most significant byte first. The block then waits out the initial latency. While the command word is on the bus, the device drives the strobe, and a high strobe on any command beat means a refresh is pending, so the latency is doubled. Writes follow with data bytes, and the block drives the strobe as a per-byte mask. Reads hand the strobe back to the device, and the block captures a byte on every strobe transition until the requested count is reached. If the strobe stops toggling for too long, the block ends the transaction and reports an error.

Top module: `psram_ctl`

## Requirements
- R1: While `rst_n` is low, `psr_cs_n` is 1, `psr_ck` is 0, `dq_oe` and `rwds_oe` are 0 and `psr_rst_n` is 0. After the first clock with `rst_n` high, `psr_rst_n` is 1 and `req_ready` is 1.
- R2: The first six beats with `psr_cs_n` low carry the command word, most significant byte first. Bit 47 is 1 for a read and 0 for a write. Bit 46 is 0, which selects memory space. Bit 45 equals `req_linear`. Bits ADDR_W-1:0 hold `req_addr`, and all other bits are 0.
- R3: When `rwds_i` is low on all six command beats, the first data beat is beat 6 + 2·`cfg_lat`, counting the first command beat as beat 0. `cfg_lat` must lie between 3 and 7.
- R4: When `rwds_i` is high on any command beat, the first data beat is beat 6 + 4·`cfg_lat`.
- R5: On each write data beat, `dq_o` carries the requested byte in order, `rwds_oe` is 1 and `rwds_o` is the inverse of `wr_be`. A byte sent with `rwds_o` high must leave the device memory unchanged.
- R6: On a read, the block captures `dq_i` on every change of `rwds_i` during the data phase. The sampled strobe level is taken as 0 when the data phase starts. Each captured byte appears in order on `rd_data`, with `rd_valid` high for one cycle, the cycle after capture. After `req_len` bytes, `done` pulses with `err` at 0.
- R7: If no strobe change is seen for TMO_CYC consecutive cycles of the read data phase, `done` and `err` pulse together, and no further bytes are delivered.
- R8: `psr_ck` is 0 whenever `psr_cs_n` is 1. While `psr_cs_n` stays low, `psr_ck` changes on every cycle, starting at 0 on the first command beat.
- R9: Between two transactions, `psr_cs_n` stays high for at least GAP_CYC cycles. `req_ready` is 0 whenever `psr_cs_n` is low.
- R10: On the write data beat with index i, counting from 0, `wr_idx` equals i. The local side answers with `wr_byte` and `wr_be` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bus byte per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lat | input | 3 | Initial latency in bus clocks (3..7), sampled at request accept |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High when idle; a request is taken on a clock with both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_linear | input | 1 | Burst type bit placed in the command word |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Byte count, 1 or more |
| wr_idx | output | LEN_W | Index of the write byte being sent |
| wr_byte | input | 8 | Write byte for `wr_idx` |
| wr_be | input | 1 | Byte enable for `wr_idx` |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transaction finished pulse |
| err | output | 1 | Strobe timeout, valid with `done` |
| psr_cs_n | output | 1 | Bus select, active low |
| psr_ck | output | 1 | Bus clock |
| psr_rst_n | output | 1 | Bus reset, active low |
| dq_o | output | 8 | Bus data out |
| dq_oe | output | 1 | Bus data output enable |
| dq_i | input | 8 | Bus data in |
| rwds_o | output | 1 | Strobe out (write mask) |
| rwds_oe | output | 1 | Strobe output enable |
| rwds_i | input | 1 | Strobe in (refresh flag, read strobe) |

## Verification
The command byte for beat k is on `dq_o` in the k-th cycle after the accepting edge. The first data beat is due 2·`cfg_lat` or 4·`cfg_lat` beats after the sixth command beat, depending on the strobe the device model drove during the command. Read bytes show up on `rd_valid` one cycle after the strobe change that carries them, and `done` comes on the same edge as the last byte. On a timeout, `done` comes TMO_CYC cycles after the last strobe change. The bench samples everything on the falling clock and counts beats from the falling edge of `psr_cs_n`. Each check compares the beat in which a result appears against the beat computed from these counts.

// File: rtl/psram_ctl_pkg.sv
package psram_ctl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CA,
      ST_LAT,
      ST_WR,
      ST_RD,
      ST_GAP
   } psr_state_e;

   localparam int CA_BEATS = 6;
   localparam int LAT_MIN  = 3;
endpackage

// File: rtl/psram_ca_gen.sv
module psram_ca_gen #(
   parameter int ADDR_W = 24
) (
   input  logic              is_read,
   input  logic              linear,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        beat,
   output logic [7:0]        ca_byte
);
   localparam int PAD_W = 45 - ADDR_W;

   logic [47:0] word;
   logic [5:0]  shamt;
   logic [47:0] shifted;

   generate
      if (ADDR_W < 1 || ADDR_W > 45) begin : g_bad_addr
         $error("psram_ca_gen: ADDR_W must be 1..45");
      end
      if (PAD_W > 0) begin : g_pad
         assign word = {is_read, 1'b0, linear, {PAD_W{1'b0}}, addr};
      end else begin : g_full
         assign word = {is_read, 1'b0, linear, addr};
      end
   endgenerate

   // beat 0 carries bits 47:40, beat 5 carries bits 7:0
   always_comb begin
      shamt   = {3'd5 - beat, 3'b000};
      shifted = word >> shamt;
      ca_byte = shifted[7:0];
   end
endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture #(
   parameter int LEN_W   = 8,
   parameter int TMO_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             en,
   input  logic             strobe_i,
   input  logic [7:0]       dq_i,
   input  logic [LEN_W-1:0] len,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic             last,
   output logic             tmo
);
   localparam int TMO_W = $clog2(TMO_CYC + 1);

   logic             prev;
   logic [LEN_W-1:0] got;
   logic [TMO_W-1:0] idle;
   logic             strb_tog;

   generate
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("psram_rd_capture: TMO_CYC must be at least 2");
      end
   endgenerate

   assign strb_tog = en && (strobe_i != prev);
   assign last     = strb_tog && (got == len - 1'b1);
   assign tmo      = en && !strb_tog && (idle == TMO_W'(TMO_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev     <= 1'b0;
         got      <= '0;
         idle     <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= strb_tog;
         if (arm) begin
            prev <= 1'b0;
            got  <= '0;
            idle <= '0;
         end else if (en) begin
            prev <= strobe_i;
            if (strb_tog) begin
               got     <= got + 1'b1;
               idle    <= '0;
               rd_data <= dq_i;
            end else begin
               idle <= idle + 1'b1;
            end
         end
      end
   end

   // R6: the controller must leave the data phase once the count is reached
   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (got < len));
   // R6: arming and capturing never overlap
   assert_arm_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arm |-> !en);
endmodule

// File: rtl/psram_ctl.sv
module psram_ctl
   import psram_ctl_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int LEN_W   = 8,
   parameter int TMO_CYC = 16,
   parameter int GAP_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_lat,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_linear,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic [LEN_W-1:0]  wr_idx,
   input  logic [7:0]        wr_byte,
   input  logic              wr_be,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              done,
   output logic              err,
   output logic              psr_cs_n,
   output logic              psr_ck,
   output logic              psr_rst_n,
   output logic [7:0]        dq_o,
   output logic              dq_oe,
   input  logic [7:0]        dq_i,
   output logic              rwds_o,
   output logic              rwds_oe,
   input  logic              rwds_i
);
   localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;

   psr_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [4:0]        lat_end;
   logic [2:0]        lat_q;
   logic              dbl;
   logic              ph;
   logic              is_read;
   logic              linear_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic              rst_q;
   logic              active;
   logic [7:0]        ca_byte;
   logic              rd_arm;
   logic              rd_en;
   logic              rd_last;
   logic              rd_tmo;
   logic              dbl_n;

   generate
      if (LEN_W < 2) begin : g_bad_len
         $error("psram_ctl: LEN_W must be at least 2");
      end
      if (GAP_CYC < 2) begin : g_bad_gap
         $error("psram_ctl: GAP_CYC must be at least 2");
      end
   endgenerate

   psram_ca_gen #(.ADDR_W(ADDR_W)) ca_i (
      .is_read (is_read),
      .linear  (linear_q),
      .addr    (addr_q),
      .beat    (cnt[2:0]),
      .ca_byte (ca_byte)
   );

   assign rd_en  = (st == ST_RD);
   assign rd_arm = (st == ST_LAT) && (cnt == CNT_W'(lat_end)) && is_read;

   psram_rd_capture #(.LEN_W(LEN_W), .TMO_CYC(TMO_CYC)) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (rd_arm),
      .en       (rd_en),
      .strobe_i (rwds_i),
      .dq_i     (dq_i),
      .len      (len_q),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .last     (rd_last),
      .tmo      (rd_tmo)
   );

   assign dbl_n = dbl | rwds_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         lat_end  <= '0;
         lat_q    <= '0;
         dbl      <= 1'b0;
         ph       <= 1'b0;
         is_read  <= 1'b0;
         linear_q <= 1'b0;
         addr_q   <= '0;
         len_q    <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         rst_q    <= 1'b0;
      end else begin
         rst_q <= 1'b1;
         done  <= 1'b0;
         err   <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  st       <= ST_CA;
                  cnt      <= '0;
                  ph       <= 1'b0;
                  dbl      <= 1'b0;
                  lat_q    <= cfg_lat;
                  is_read  <= !req_write;
                  linear_q <= req_linear;
                  addr_q   <= req_addr;
                  len_q    <= req_len;
               end
            end
            ST_CA: begin
               ph <= ~ph;
               if (rwds_i) dbl <= 1'b1;
               if (cnt == CNT_W'(CA_BEATS - 1)) begin
                  st      <= ST_LAT;
                  cnt     <= '0;
                  lat_end <= dbl_n ? ({lat_q, 2'b00} - 5'd1) : ({1'b0, lat_q, 1'b0} - 5'd1);
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_LAT: begin
               ph <= ~ph;
               if (cnt == CNT_W'(lat_end)) begin
                  st  <= is_read ? ST_RD : ST_WR;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WR: begin
               ph <= ~ph;
               if (cnt == CNT_W'(len_q - 1'b1)) begin
                  st   <= ST_GAP;
                  cnt  <= '0;
                  done <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_RD: begin
               ph <= ~ph;
               if (rd_last || rd_tmo) begin
                  st   <= ST_GAP;
                  cnt  <= '0;
                  done <= 1'b1;
                  err  <= rd_tmo;
               end
            end
            ST_GAP: begin
               ph <= 1'b0;
               if (cnt == CNT_W'(GAP_CYC - 1)) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      active    = (st == ST_CA) || (st == ST_LAT) || (st == ST_WR) || (st == ST_RD);
      req_ready = (st == ST_IDLE);
      psr_cs_n  = !active;
      psr_ck    = active && ph;
      psr_rst_n = rst_q;
      dq_oe     = (st == ST_CA) || (st == ST_WR);
      dq_o      = (st == ST_CA) ? ca_byte : ((st == ST_WR) ? wr_byte : 8'h00);
      rwds_oe   = (st == ST_WR);
      rwds_o    = (st == ST_WR) && !wr_be;
      wr_idx    = (st == ST_WR) ? cnt[LEN_W-1:0] : '0;
   end

   // R8: bus clock parked low while deselected
   assert_ck_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      psr_cs_n |-> !psr_ck);
   // R9: select stays high for more than one cycle after a transaction
   assert_min_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(psr_cs_n) |=> psr_cs_n);
   // R2: a transaction opens with the controller driving the command
   assert_ca_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psr_cs_n) |-> (dq_oe && !rwds_oe));
   // R5: the mask is only driven inside a selected transaction
   assert_mask_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rwds_oe |-> !psr_cs_n);
   // R3: latency setting stays in its legal range
   assert_lat_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (cfg_lat >= 3'(LAT_MIN)));
   // R6: zero-length requests are not allowed
   assert_len_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (req_len != '0));
   // R7: a timeout never coincides with a delivered byte
   assert_tmo_no_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !rd_valid));
endmodule

// File: tb/psram_ctl_tb.sv
`timescale 1ns/1ps
module psram_ctl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [2:0]  cfg_lat;
   logic        req_valid;
   logic        req_ready;
   logic        req_write;
   logic        req_linear;
   logic [23:0] req_addr;
   logic [7:0]  req_len;
   logic [7:0]  wr_idx;
   logic [7:0]  wr_byte;
   logic        wr_be;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        done;
   logic        err;
   logic        psr_cs_n;
   logic        psr_ck;
   logic        psr_rst_n;
   logic [7:0]  dq_o;
   logic        dq_oe;
   logic [7:0]  dq_i;
   logic        rwds_o;
   logic        rwds_oe;
   logic        rwds_i;

   always #2.5 clk = ~clk;

   logic [7:0] wsrc    [256];
   logic       wbe     [256];
   logic [7:0] dev_mem [256];
   logic [7:0] exp_mem [256];
   logic [7:0] got     [256];

   assign wr_byte = wsrc[wr_idx];
   assign wr_be   = wbe[wr_idx];

   psram_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_lat(cfg_lat),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_linear(req_linear), .req_addr(req_addr), .req_len(req_len),
      .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_be(wr_be),
      .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
      .psr_cs_n(psr_cs_n), .psr_ck(psr_ck), .psr_rst_n(psr_rst_n),
      .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i),
      .rwds_o(rwds_o), .rwds_oe(rwds_oe), .rwds_i(rwds_i)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // device model and bus monitors, all on the falling edge
   int          beat = 0;
   int          cur_lat = 3;
   int          cur_flag = 0;
   bit          cur_write = 0;
   int          stall_after = 1000;
   int          first_oe = -1;
   int          hi_run = 100;
   logic        prev_cs = 1'b1;
   logic        prev_ck = 1'b0;
   logic [47:0] ca_cap = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         beat   = 0;
         rwds_i = 1'b0;
         dq_i   = 8'h00;
      end else begin
         if (psr_cs_n) begin
            chk("R8 ck low while deselected", psr_ck, 1'b0);
            hi_run++;
            beat   = 0;
            rwds_i = 1'b0;
         end else begin
            automatic int ds = 6 + (cur_flag ? 4 : 2) * cur_lat;
            if (prev_cs) begin
               chk("R9 deselect gap ok", (hi_run >= 2), 1'b1);
               chk("R8 ck starts low", psr_ck, 1'b0);
            end else begin
               chk("R8 ck toggles", psr_ck, !prev_ck);
            end
            hi_run = 0;
            chk("R9 not ready while selected", req_ready, 1'b0);
            if (rwds_oe && first_oe < 0) first_oe = beat;
            if (beat < 6) begin
               ca_cap = {ca_cap[39:0], dq_o};
               rwds_i = (cur_flag != 0);
            end else if (beat < ds) begin
               rwds_i = 1'b0;
            end else begin
               automatic int i = beat - ds;
               automatic logic [7:0] a = 8'(ca_cap[7:0] + 8'(i));
               if (cur_write) begin
                  if (rwds_oe) begin
                     chk("R10 write index", wr_idx, 8'(i));
                     chk("R5 write byte", dq_o, wsrc[i]);
                     chk("R5 write mask", rwds_o, !wbe[i]);
                     if (!rwds_o) dev_mem[a] = dq_o;
                  end
               end else if (i < stall_after) begin
                  dq_i   = dev_mem[a];
                  rwds_i = ~rwds_i;
               end
            end
            beat++;
         end
         prev_cs = psr_cs_n;
         prev_ck = psr_ck;
      end
   end

   task automatic run_txn(input bit wr, input bit lin, input int addr, input int len,
                          input int lat, input int flag, input int stall);
      int n;
      int wd;
      int ds;
      logic [47:0] exp_ca;
      @(negedge clk);
      cur_write   = wr;
      cur_lat     = lat;
      cur_flag    = flag;
      stall_after = stall;
      first_oe    = -1;
      cfg_lat     = 3'(lat);
      req_write   = wr;
      req_linear  = lin;
      req_addr    = 24'(addr);
      req_len     = 8'(len);
      req_valid   = 1'b1;
      wd = 0;
      while (!req_ready && wd < 100) begin
         @(negedge clk);
         wd++;
      end
      @(negedge clk);
      req_valid = 1'b0;
      n  = 0;
      wd = 0;
      forever begin
         if (rd_valid) begin
            got[n[7:0]] = rd_data;
            n++;
         end
         if (done || wd > 3000) break;
         @(negedge clk);
         wd++;
      end
      chk("R6 watchdog on transaction end", (wd <= 3000), 1'b1);
      ds = 6 + (flag ? 4 : 2) * lat;
      exp_ca = {!wr, 1'b0, lin, 21'd0, 24'(addr)};
      chk("R2 command word", ca_cap, exp_ca);
      if (wr) begin
         if (flag != 0) chk("R4 doubled latency first data beat", first_oe, ds);
         else           chk("R3 base latency first data beat", first_oe, ds);
         chk("R5 write err", err, 1'b0);
         for (int i = 0; i < len; i++)
            if (wbe[i]) exp_mem[8'(addr + i)] = wsrc[i];
      end else begin
         if (stall >= len) begin
            chk("R6 read byte count", n, len);
            chk("R6 read err", err, 1'b0);
         end else begin
            chk("R7 timeout err", err, 1'b1);
            chk("R7 bytes before timeout", n, stall);
         end
         for (int i = 0; i < n; i++)
            chk("R6/R5 read byte value", got[i], exp_mem[8'(addr + i)]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      req_valid  = 1'b0;
      req_write  = 1'b0;
      req_linear = 1'b0;
      req_addr   = '0;
      req_len    = 8'd1;
      cfg_lat    = 3'd3;
      for (int i = 0; i < 256; i++) begin
         dev_mem[i] = 8'(i) ^ 8'h5A;
         exp_mem[i] = 8'(i) ^ 8'h5A;
         wsrc[i]    = 8'h00;
         wbe[i]     = 1'b1;
      end
      repeat (3) @(negedge clk);
      chk("R1 cs_n in reset", psr_cs_n, 1'b1);
      chk("R1 ck in reset", psr_ck, 1'b0);
      chk("R1 dq_oe in reset", dq_oe, 1'b0);
      chk("R1 rwds_oe in reset", rwds_oe, 1'b0);
      chk("R1 bus reset asserted", psr_rst_n, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 bus reset released", psr_rst_n, 1'b1);
      chk("R1 ready after reset", req_ready, 1'b1);

      for (int lat = 3; lat <= 7; lat++) begin
         for (int flag = 0; flag <= 1; flag++) begin
            automatic int len  = 3 + lat + flag;
            automatic int addr = (lat * 37 + flag * 90) & 255;
            for (int i = 0; i < len; i++) begin
               wsrc[i] = 8'(lat * 16 + i * 7 + flag);
               wbe[i]  = ((i % 3) != 1);
            end
            run_txn(1'b1, flag[0], addr, len, lat, flag, 1000);
            run_txn(1'b0, !flag[0], addr, len, lat, 1 - flag, 1000);
         end
      end
      // single-byte read and a read straddling the top of the model memory
      run_txn(1'b0, 1'b1, 200, 1, 4, 0, 1000);
      run_txn(1'b0, 1'b0, 250, 12, 5, 1, 1000);
      // strobe stalls after three bytes, then never toggles at all
      run_txn(1'b0, 1'b1, 16, 8, 3, 0, 3);
      run_txn(1'b0, 1'b1, 40, 4, 6, 1, 0);
      // normal read after timeouts
      run_txn(1'b0, 1'b0, 111, 9, 7, 0, 1000);

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule